// File: doc/BRIEF.md
# Latched-Address Register Slave Port

This block is the slave side of a register-access path for a peripheral that shares a multiplexed 16-bit address/data bus with its host. The host selects the device with an active-low chip select. It offers a 4-bit register number on dedicated address pins, qualified by an address strobe. While that strobe is high the number flows straight through to the register decode. When the strobe falls, the number last seen is held. The host then moves one byte of register data on the low half of the shared bus, using separate active-low read and write strobes. The device answers each access with an acknowledge.

Reads drive the low byte only while the access is live. The upper byte is never driven. Writes are committed when the write strobe is released, into the register whose number was latched, using the byte sampled while the strobe was active. When the device itself owns the bus as master (bus-grant input high), the port ignores every strobe.

Top module: `lar_slave_port`

## Requirements
- R1: After reset (rst_ni low), ack_o is 0, bus_oe_o is all zeros, the held address is 0 and every register reads back 0x00.
- R2: While addr_strobe_i is 1, the register selected for a read follows reg_addr_i in the same cycle.
- R3: Once addr_strobe_i is 0, the selected register stays the one whose number was on reg_addr_i at the last rising clock edge with the strobe high. Later changes on reg_addr_i have no effect.
- R4: bus_o[7:0] carries the selected register and bus_oe_o[7:0] is 0xFF exactly while cs_ni=0, slv_rd_ni=0 and bus_grant_i=0. Otherwise bus_oe_o[7:0] is 0x00.
- R5: bus_oe_o[15:8] is 0x00 at all times.
- R6: A write takes bus_i[7:0] and the held address from the last clock edge of the active write. It commits them one clock after slv_wr_ni returns high, even if the address latch has reopened to a different address by then.
- R7: ack_o rises one clock after a qualified read or write strobe is sampled, stays high while the strobe is held, and falls one clock after it is released.
- R8: With bus_grant_i=1, read and write strobes produce no ack, no bus drive and no register change.
- R9: With cs_ni=1, read and write strobes produce no ack, no bus drive and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| bus_grant_i | input | 1 | High while the device is bus master; port inactive |
| addr_strobe_i | input | 1 | Address latch enable, transparent while high |
| reg_addr_i | input | 4 | Register number |
| slv_rd_ni | input | 1 | Slave read strobe, active low |
| slv_wr_ni | input | 1 | Slave write strobe, active low |
| bus_i | input | 8 | Low byte of the shared bus as seen by the port |
| bus_o | output | 16 | Value driven onto the shared bus |
| bus_oe_o | output | 16 | Per-bit output enable; 0 means high impedance |
| ack_o | output | 1 | Access acknowledge |

## Verification
Two functions can fall in the same cycle: the commit of a finished write, and the address latch reopening for the next access. The bench raises the address strobe with a different register number in the very cycle the write strobe is released, and it changes the data on the bus at the same moment. It then reads back both the old and the new register. The write must land only in the register that was latched, with the byte that was present during the active strobe.

// File: rtl/lar_pkg.sv
package lar_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BUS_W  = 16;
endpackage

// File: rtl/lar_addr_latch.sv
module lar_addr_latch #(
  parameter int unsigned ADDR_W = lar_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] held_q;

  // held copy is refreshed every edge while open; output bypasses it while open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= '0;
    else if (le_i) held_q <= addr_i;
  end

  assign addr_o = le_i ? addr_i : held_q;
endmodule

// File: rtl/lar_strobe_ctrl.sv
module lar_strobe_ctrl #(
  parameter int unsigned ADDR_W = lar_pkg::ADDR_W,
  parameter int unsigned DATA_W = lar_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              grant_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_en_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              ack_o
);
  logic sel;
  logic wr_act;
  logic wr_q;
  logic ack_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  assign sel     = !cs_ni && !grant_i;
  assign rd_en_o = sel && !rd_ni;
  assign wr_act  = sel && !wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      wr_q  <= wr_act;
      ack_q <= rd_en_o || wr_act;
      if (wr_act) begin
        waddr_q <= addr_i;
        wdata_q <= data_i;
      end
    end
  end

  // commit on release of the write strobe itself, never under bus grant
  assign commit_o = wr_q && wr_ni && !grant_i;
  assign waddr_o  = waddr_q;
  assign wdata_o  = wdata_q;
  assign ack_o    = ack_q;
endmodule

// File: rtl/lar_reg_file.sv
module lar_reg_file #(
  parameter int unsigned ADDR_W = lar_pkg::ADDR_W,
  parameter int unsigned DATA_W = lar_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && (waddr_i == ADDR_W'(g)))     regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/lar_slave_port.sv
module lar_slave_port #(
  parameter int unsigned ADDR_W = lar_pkg::ADDR_W,
  parameter int unsigned DATA_W = lar_pkg::DATA_W,
  parameter int unsigned BUS_W  = lar_pkg::BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              bus_grant_i,
  input  logic              addr_strobe_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              slv_rd_ni,
  input  logic              slv_wr_ni,
  input  logic [DATA_W-1:0] bus_i,
  output logic [BUS_W-1:0]  bus_o,
  output logic [BUS_W-1:0]  bus_oe_o,
  output logic              ack_o
);
  localparam int unsigned HI_W = BUS_W - DATA_W;

  logic [ADDR_W-1:0] addr_eff;
  logic              rd_en;
  logic              commit;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;

  lar_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_i  (addr_strobe_i),
    .addr_i(reg_addr_i),
    .addr_o(addr_eff)
  );

  lar_strobe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .grant_i (bus_grant_i),
    .rd_ni   (slv_rd_ni),
    .wr_ni   (slv_wr_ni),
    .addr_i  (addr_eff),
    .data_i  (bus_i),
    .rd_en_o (rd_en),
    .commit_o(commit),
    .waddr_o (waddr),
    .wdata_o (wdata),
    .ack_o   (ack_o)
  );

  lar_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (commit),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(addr_eff),
    .rdata_o(rdata)
  );

  // upper byte is never driven
  assign bus_o    = {{HI_W{1'b0}}, (rd_en ? rdata : {DATA_W{1'b0}})};
  assign bus_oe_o = {{HI_W{1'b0}}, {DATA_W{rd_en}}};
endmodule

// File: rtl/lar_slave_port_chk.sv
module lar_slave_port_chk #(
  parameter int unsigned ADDR_W = lar_pkg::ADDR_W,
  parameter int unsigned DATA_W = lar_pkg::DATA_W,
  parameter int unsigned BUS_W  = lar_pkg::BUS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              bus_grant_i,
  input logic              addr_strobe_i,
  input logic              slv_rd_ni,
  input logic              slv_wr_ni,
  input logic [BUS_W-1:0]  bus_oe_o,
  input logic              ack_o,
  input logic [ADDR_W-1:0] addr_eff
);
  logic live;
  assign live = !cs_ni && !bus_grant_i && (!slv_rd_ni || !slv_wr_ni);

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!ack_o && bus_oe_o == '0));

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_strobe_i && $past(!addr_strobe_i)) |-> $stable(addr_eff));

  assert_drive_qual_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o[DATA_W-1:0] != '0) |-> (!cs_ni && !slv_rd_ni && !bus_grant_i));

  assert_hi_float_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o[BUS_W-1:DATA_W] == '0);

  assert_ack_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |=> ack_o);

  assert_ack_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |=> !ack_o);

  assert_grant_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant_i |=> !ack_o);

  assert_cs_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (bus_oe_o == '0));
endmodule

bind lar_slave_port lar_slave_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .bus_grant_i  (bus_grant_i),
  .addr_strobe_i(addr_strobe_i),
  .slv_rd_ni    (slv_rd_ni),
  .slv_wr_ni    (slv_wr_ni),
  .bus_oe_o     (bus_oe_o),
  .ack_o        (ack_o),
  .addr_eff     (addr_eff)
);

// File: tb/lar_slave_port_tb.sv
`timescale 1ns/1ps
module lar_slave_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cs_ni;
  logic        bus_grant_i;
  logic        addr_strobe_i;
  logic [3:0]  reg_addr_i;
  logic        slv_rd_ni;
  logic        slv_wr_ni;
  logic [7:0]  bus_i;
  logic [15:0] bus_o;
  logic [15:0] bus_oe_o;
  logic        ack_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] model [16];

  always #10 clk_i = ~clk_i;

  lar_slave_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .bus_grant_i(bus_grant_i),
    .addr_strobe_i(addr_strobe_i), .reg_addr_i(reg_addr_i),
    .slv_rd_ni(slv_rd_ni), .slv_wr_ni(slv_wr_ni), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .ack_o(ack_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_oe(input bit live);
    return live ? 32'h00FF : 32'h0000;
  endfunction

  task automatic idle();
    cs_ni = 1'b1; bus_grant_i = 1'b0; addr_strobe_i = 1'b0;
    slv_rd_ni = 1'b1; slv_wr_ni = 1'b1;
  endtask

  // mode: 0 normal, 1 bus granted, 2 chip not selected
  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input int mode,
                          input bit reopen);
    @(negedge clk_i);
    cs_ni = (mode == 2); bus_grant_i = (mode == 1);
    addr_strobe_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    addr_strobe_i = 1'b0; reg_addr_i = 4'($urandom); slv_wr_ni = 1'b0; bus_i = d;
    @(negedge clk_i);
    chk(mode == 0 ? "R7 write ack" : (mode == 1 ? "R8 write ack" : "R9 write ack"),
        int'(ack_o), int'(mode == 0));
    if (reopen) begin
      addr_strobe_i = 1'b1; reg_addr_i = a ^ 4'hF;
    end
    slv_wr_ni = 1'b1; bus_i = 8'($urandom);
    @(negedge clk_i);
    chk("R7 ack falls", int'(ack_o), 0);
    idle();
    if (mode == 0) model[a] = d;
  endtask

  task automatic do_read(input logic [3:0] a, input int mode, input string tag);
    @(negedge clk_i);
    cs_ni = (mode == 2); bus_grant_i = (mode == 1);
    addr_strobe_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    addr_strobe_i = 1'b0; reg_addr_i = 4'($urandom); slv_rd_ni = 1'b0;
    #2;
    chk({tag, " oe"}, int'(bus_oe_o), exp_oe(mode == 0));
    if (mode == 0) chk({tag, " data"}, int'(bus_o[7:0]), int'(model[a]));
    @(negedge clk_i);
    chk({tag, " R7 ack"}, int'(ack_o), int'(mode == 0));
    idle();
    #2;
    chk("R4 release", int'(bus_oe_o), 0);
    @(negedge clk_i);
    chk("R7 ack falls after read", int'(ack_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    idle(); reg_addr_i = 4'h0; bus_i = 8'h00; rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 ack in reset", int'(ack_o), 0);
    chk("R1 oe in reset", int'(bus_oe_o), 0);
    rst_ni = 1'b1;
    // R1: latch empty, registers clear
    @(negedge clk_i);
    cs_ni = 1'b0; slv_rd_ni = 1'b0; #2;
    chk("R1 held address zero", int'(bus_o[7:0]), 0);
    idle();
    for (int i = 0; i < 16; i++) do_read(4'(i), 0, "R1 cleared");

    // R2: transparent latch follows address while strobe high
    for (int i = 0; i < 16; i++) do_write(4'(i), 8'(8'hA0 + i), 0, 1'b0);
    @(negedge clk_i);
    cs_ni = 1'b0; addr_strobe_i = 1'b1; reg_addr_i = 4'h3; slv_rd_ni = 1'b0; #2;
    chk("R2 flow a", int'(bus_o[7:0]), int'(model[3]));
    @(negedge clk_i); reg_addr_i = 4'hC; #2;
    chk("R2 flow b", int'(bus_o[7:0]), int'(model[12]));
    @(negedge clk_i); addr_strobe_i = 1'b0; reg_addr_i = 4'h1; #2;
    chk("R3 held after fall", int'(bus_o[7:0]), int'(model[12]));
    idle();

    // R6: commit concurrent with latch reopening and bus data change
    do_write(4'h5, 8'h3C, 0, 1'b1);
    do_read(4'h5, 0, "R6 target");
    do_read(4'hA, 0, "R6 bystander");

    // R8 / R9 ignored strobes leave registers alone
    do_write(4'h7, 8'h11, 1, 1'b0);
    do_read(4'h7, 0, "R8 unchanged");
    do_write(4'h7, 8'h22, 2, 1'b0);
    do_read(4'h7, 0, "R9 unchanged");
    do_read(4'h7, 1, "R8 read");
    do_read(4'h7, 2, "R9 read");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] a = 4'($urandom);
      logic [7:0] d = 8'($urandom);
      int m = int'($urandom % 5);
      int mode = (m >= 3) ? 0 : m;
      if ($urandom % 2) do_write(a, d, mode, 1'($urandom));
      else              do_read(a, mode, "R4 random read");
    end
    for (int i = 0; i < 16; i++) do_read(4'(i), 0, "R6 final");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule